// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between the clock generators of a system clock chip and its output pads. For every clock output lane it decides whether the running clock is passed through or held low. It also decides whether the lanes that can float are driven. It combines four kinds of control. The first is an active-low power-down pin. The second is an active-low CPU stop pin, which only counts when the latched mode strap turns that pin into an input. The third is a set of per-lane run bits from the configuration registers. The fourth is one test bit that floats the outputs for board testing.

Stopped outputs are actively held low, with one exception. The complementary CPU output is released to high impedance whenever the CPU lanes stop. Each lane's enable is held in a flop that updates only on the falling edge of that lane's own clock. As a result, an enable change never cuts a high pulse short and never creates a runt pulse. The asynchronous power-down and stop pins are resynchronised in each clock domain before they are used.

The lanes are grouped into six clock domains: CPU, PCI, SDRAM, reference, 48 MHz and 24/48 MHz. Each domain gets its clock on its own port. Clock synthesis and frequency selection happen elsewhere.

Top module: `clkgate_ctrl`

## Requirements
- R1: While `pwrdn_n` is low, `cpu_c_oe` is 0 and every gated clock output (`cpu_t`, `cpu_cs`, `pci_out`, `sdram_out`, `ref_out`, `usb_out`, `sio_out`) stays low.
- R2: While `mode_strap` is 1 and `cpustop_n` is low, `cpu_t` and `cpu_cs` stay low and `cpu_c_oe` is 0. The PCI, SDRAM, reference, 48 MHz and 24/48 MHz lanes keep toggling.
- R3: A run bit of 0 holds its lane low, and a run bit of 1 lets the lane's clock through. Bit i of `pci_run` controls `pci_out[i]`, bit i of `ref_run` controls `ref_out[i]`, `usb_run` controls `usb_out` and `sio_run` controls `sio_out`.
- R4: The SDRAM lanes are enabled in groups of `SDRAM_GROUP`. Bit g of `sdram_grp_run` controls lanes g*4 to g*4+3 (default sizing), and `sdram_tail_run` controls the lanes left over above the last full group (lane 12 by default).
- R5: With `mode_strap` at 0, `cpustop_n` has no effect, `ref0_oe` follows `~test_hiz` and `ref_out[0]` is gated by `ref_run[0]`. With `mode_strap` at 1, `ref0_oe` is 0 and `ref_out[0]` stays low.
- R6: While `test_hiz` is 1, `clk_oe`, `cpu_c_oe` and `ref0_oe` are 0, and the gated lanes keep their running state.
- R7: While the CPU lanes run, `cpu_c` is the inverse of `cpu_clk`: high in its low phase and low in its high phase.
- R8: Every gated output is low throughout the low phase of its own clock. Whenever a high pulse appears, it lasts the whole high phase.
- R9: A run bit changed during a clock's low phase leaves the next high phase unchanged and takes effect on the high phase after it.
- R10: `pwrdn_n` and `cpustop_n` pass through `SYNC_STAGES` flops on the lane clock. With 2 stages, a stop applied in a low phase leaves the next two high pulses intact and suppresses the third.
- R11: While `rst_n` is low, all gated outputs are low and `cpu_c_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | Running CPU clock |
| pci_clk | input | 1 | Running PCI clock |
| sdram_clk | input | 1 | Buffered SDRAM feedback clock |
| ref_clk | input | 1 | Reference oscillator clock |
| usb_clk | input | 1 | 48 MHz clock |
| sio_clk | input | 1 | 24/48 MHz clock |
| pwrdn_n | input | 1 | Asynchronous power-down, active low |
| cpustop_n | input | 1 | Asynchronous CPU stop, active low, used only when mode_strap is 1 |
| mode_strap | input | 1 | Latched strap: 1 makes the shared pin a stop input |
| test_hiz | input | 1 | Board-test float request |
| pci_run | input | PCI_LANES | Per-lane PCI run bits |
| sdram_grp_run | input | SDRAM_LANES/SDRAM_GROUP | SDRAM group run bits |
| sdram_tail_run | input | 1 | Run bit for SDRAM lanes above the last group |
| ref_run | input | REF_LANES | Per-lane reference run bits |
| usb_run | input | 1 | 48 MHz lane run bit |
| sio_run | input | 1 | 24/48 MHz lane run bit |
| cpu_t | output | 1 | Gated true CPU clock |
| cpu_cs | output | 1 | Gated chipset copy of the CPU clock |
| cpu_c | output | 1 | Complementary CPU clock |
| cpu_c_oe | output | 1 | Output enable of cpu_c |
| pci_out | output | PCI_LANES | Gated PCI clocks |
| sdram_out | output | SDRAM_LANES | Gated SDRAM clocks |
| ref_out | output | REF_LANES | Gated reference clocks |
| usb_out | output | 1 | Gated 48 MHz clock |
| sio_out | output | 1 | Gated 24/48 MHz clock |
| clk_oe | output | 1 | Common output enable of the push-pull lanes |
| ref0_oe | output | 1 | Output enable of the shared reference/stop pin |

## Verification
The bench uses the default sizing: six PCI lanes, thirteen SDRAM lanes in groups of four with one tail lane, two reference lanes and a two-stage synchroniser. All six lane clocks are tied to one bench clock. Sharing one clock makes the exact cycle of every enable change predictable. The one-cycle run-bit latency (R9) and the two-high-pulse stop latency (R10) can therefore be checked edge by edge. Because thirteen is not a multiple of four, the default sizing also exercises the tail lane's separate run bit.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Asynchronous stop requests entering a clock domain (both active low).
  typedef struct packed {
    logic pd_n;
    logic stop_n;
  } clkgate_req_t;

  // Lane index -> group index, used to fan SDRAM group bits out to lanes.
  function automatic int unsigned grp_of(input int unsigned lane, input int unsigned grp_size);
    return lane / grp_size;
  endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  // Resets to 0 so a lane comes out of reset stopped.
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic en
);
  // Enable captured on the falling edge: it only moves while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= run;
  end
endmodule

// File: rtl/clkgate_domain.sv
module clkgate_domain
  import clkgate_pkg::*;
#(
  parameter int unsigned LANES    = 1,
  parameter int unsigned STAGES   = 2,
  parameter bit          USE_STOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  clkgate_req_t      req,
  input  logic [LANES-1:0]  run_cfg,
  output logic [LANES-1:0]  en
);
  logic pd_ok;
  logic stop_ok;

  clkgate_sync #(.STAGES(STAGES)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d(req.pd_n), .q(pd_ok)
  );

  generate
    if (USE_STOP) begin : g_stop
      clkgate_sync #(.STAGES(STAGES)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .d(req.stop_n), .q(stop_ok)
      );
    end else begin : g_nostop
      logic unused_stop;
      assign unused_stop = req.stop_n;
      assign stop_ok = 1'b1;
    end
  endgenerate

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    clkgate_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .run(pd_ok & stop_ok & run_cfg[i]),
      .en(en[i])
    );
  end
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int unsigned PCI_LANES   = 6,
  parameter int unsigned SDRAM_LANES = 13,
  parameter int unsigned SDRAM_GROUP = 4,
  parameter int unsigned REF_LANES   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                 rst_n,
  input  logic                                 cpu_clk,
  input  logic                                 pci_clk,
  input  logic                                 sdram_clk,
  input  logic                                 ref_clk,
  input  logic                                 usb_clk,
  input  logic                                 sio_clk,
  input  logic                                 pwrdn_n,
  input  logic                                 cpustop_n,
  input  logic                                 mode_strap,
  input  logic                                 test_hiz,
  input  logic [PCI_LANES-1:0]                 pci_run,
  input  logic [SDRAM_LANES/SDRAM_GROUP-1:0]   sdram_grp_run,
  input  logic                                 sdram_tail_run,
  input  logic [REF_LANES-1:0]                 ref_run,
  input  logic                                 usb_run,
  input  logic                                 sio_run,
  output logic                                 cpu_t,
  output logic                                 cpu_cs,
  output logic                                 cpu_c,
  output logic                                 cpu_c_oe,
  output logic [PCI_LANES-1:0]                 pci_out,
  output logic [SDRAM_LANES-1:0]               sdram_out,
  output logic [REF_LANES-1:0]                 ref_out,
  output logic                                 usb_out,
  output logic                                 sio_out,
  output logic                                 clk_oe,
  output logic                                 ref0_oe
);
  localparam int unsigned SDRAM_GROUPS = SDRAM_LANES / SDRAM_GROUP;
  localparam int unsigned GROUPED      = SDRAM_GROUPS * SDRAM_GROUP;

  // Stop pin only counts when the strap turns the shared pin into an input.
  clkgate_req_t cpu_req, std_req;
  assign cpu_req = '{pd_n: pwrdn_n, stop_n: (mode_strap ? cpustop_n : 1'b1)};
  assign std_req = '{pd_n: pwrdn_n, stop_n: 1'b1};

  // CPU domain: lane 0 true, lane 1 chipset copy.
  logic [1:0] cpu_en;
  clkgate_domain #(.LANES(2), .STAGES(SYNC_STAGES), .USE_STOP(1'b1)) u_cpu (
    .clk(cpu_clk), .rst_n(rst_n), .req(cpu_req), .run_cfg(2'b11), .en(cpu_en)
  );
  assign cpu_t  = cpu_clk & cpu_en[0];
  assign cpu_cs = cpu_clk & cpu_en[1];
  // Complement restarts on the same falling edge that updates the enable.
  assign cpu_c    = cpu_en[0] & ~cpu_clk;
  assign cpu_c_oe = cpu_en[0] & ~test_hiz;

  logic [PCI_LANES-1:0] pci_en;
  clkgate_domain #(.LANES(PCI_LANES), .STAGES(SYNC_STAGES)) u_pci (
    .clk(pci_clk), .rst_n(rst_n), .req(std_req), .run_cfg(pci_run), .en(pci_en)
  );
  assign pci_out = {PCI_LANES{pci_clk}} & pci_en;

  // SDRAM run bits fanned out by group; lanes above the last group share the tail bit.
  logic [SDRAM_LANES-1:0] sdram_cfg, sdram_en;
  for (genvar i = 0; i < SDRAM_LANES; i++) begin : g_sdcfg
    if (i < GROUPED) begin : g_grp
      assign sdram_cfg[i] = sdram_grp_run[grp_of(i, SDRAM_GROUP)];
    end else begin : g_tail
      assign sdram_cfg[i] = sdram_tail_run;
    end
  end
  clkgate_domain #(.LANES(SDRAM_LANES), .STAGES(SYNC_STAGES)) u_sdram (
    .clk(sdram_clk), .rst_n(rst_n), .req(std_req), .run_cfg(sdram_cfg), .en(sdram_en)
  );
  assign sdram_out = {SDRAM_LANES{sdram_clk}} & sdram_en;

  // Reference lane 0 is silenced while its pin serves as the stop input.
  logic [REF_LANES-1:0] ref_cfg, ref_en;
  assign ref_cfg = ref_run & ~{{(REF_LANES-1){1'b0}}, mode_strap};
  clkgate_domain #(.LANES(REF_LANES), .STAGES(SYNC_STAGES)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .req(std_req), .run_cfg(ref_cfg), .en(ref_en)
  );
  assign ref_out = {REF_LANES{ref_clk}} & ref_en;

  logic usb_en, sio_en;
  clkgate_domain #(.LANES(1), .STAGES(SYNC_STAGES)) u_usb (
    .clk(usb_clk), .rst_n(rst_n), .req(std_req), .run_cfg(usb_run), .en(usb_en)
  );
  clkgate_domain #(.LANES(1), .STAGES(SYNC_STAGES)) u_sio (
    .clk(sio_clk), .rst_n(rst_n), .req(std_req), .run_cfg(sio_run), .en(sio_en)
  );
  assign usb_out = usb_clk & usb_en;
  assign sio_out = sio_clk & sio_en;

  assign clk_oe  = ~test_hiz;
  assign ref0_oe = ~mode_strap & ~test_hiz;
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
  parameter int unsigned PCI_LANES   = 6,
  parameter int unsigned SDRAM_LANES = 13,
  parameter int unsigned REF_LANES   = 2
) (
  input logic                   rst_n,
  input logic                   cpu_clk,
  input logic                   pci_clk,
  input logic                   sdram_clk,
  input logic                   ref_clk,
  input logic                   pwrdn_n,
  input logic                   cpustop_n,
  input logic                   mode_strap,
  input logic [PCI_LANES-1:0]   pci_run,
  input logic                   cpu_t,
  input logic                   cpu_cs,
  input logic                   cpu_c_oe,
  input logic [PCI_LANES-1:0]   pci_out,
  input logic [SDRAM_LANES-1:0] sdram_out,
  input logic [REF_LANES-1:0]   ref_out,
  input logic                   ref0_oe
);
  // Falling-edge sampling sees the high-phase value of the gated outputs.
  AST_PD_QUIET: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (!pwrdn_n && $past(!pwrdn_n) && $past(!pwrdn_n, 2)) |-> (pci_out == '0)); // R1

  AST_STOP_CPU: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (mode_strap && !cpustop_n && $past(mode_strap && !cpustop_n) && $past(mode_strap && !cpustop_n, 2))
    |-> (!cpu_t && !cpu_cs && !cpu_c_oe)); // R2

  AST_RUN_BIT_LOW: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (!pci_run[0] && $past(!pci_run[0])) |-> !pci_out[0]); // R3

  AST_REF0_INPUT: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (mode_strap && $past(mode_strap)) |-> (!ref0_oe && !ref_out[0])); // R5

  // Rising-edge sampling sees the low-phase value.
  AST_LOW_PHASE_QUIET: assert property (@(posedge sdram_clk) disable iff (!rst_n)
    sdram_out == '0); // R8
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(
  .PCI_LANES(PCI_LANES), .SDRAM_LANES(SDRAM_LANES), .REF_LANES(REF_LANES)
) u_chk (
  .rst_n(rst_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdram_clk(sdram_clk),
  .ref_clk(ref_clk), .pwrdn_n(pwrdn_n), .cpustop_n(cpustop_n),
  .mode_strap(mode_strap), .pci_run(pci_run), .cpu_t(cpu_t), .cpu_cs(cpu_cs),
  .cpu_c_oe(cpu_c_oe), .pci_out(pci_out), .sdram_out(sdram_out),
  .ref_out(ref_out), .ref0_oe(ref0_oe)
);

// File: tb/clkgate_ctrl_bench.sv
module clkgate_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pwrdn_n, cpustop_n, mode_strap, test_hiz;
  logic [5:0] pci_run;
  logic [2:0] sdram_grp_run;
  logic sdram_tail_run, usb_run, sio_run;
  logic [1:0] ref_run;
  logic cpu_t, cpu_cs, cpu_c, cpu_c_oe, usb_out, sio_out, clk_oe, ref0_oe;
  logic [5:0] pci_out;
  logic [12:0] sdram_out;
  logic [1:0] ref_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  clkgate_ctrl u_clkgate_ctrl (
    .rst_n(rst_n), .cpu_clk(clk), .pci_clk(clk), .sdram_clk(clk), .ref_clk(clk),
    .usb_clk(clk), .sio_clk(clk), .pwrdn_n(pwrdn_n), .cpustop_n(cpustop_n),
    .mode_strap(mode_strap), .test_hiz(test_hiz), .pci_run(pci_run),
    .sdram_grp_run(sdram_grp_run), .sdram_tail_run(sdram_tail_run),
    .ref_run(ref_run), .usb_run(usb_run), .sio_run(sio_run),
    .cpu_t(cpu_t), .cpu_cs(cpu_cs), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe),
    .pci_out(pci_out), .sdram_out(sdram_out), .ref_out(ref_out),
    .usb_out(usb_out), .sio_out(sio_out), .clk_oe(clk_oe), .ref0_oe(ref0_oe)
  );

  // Stimulus: {pd_n, stop_n, strap, hiz, pci_run[6], grp[3], tail, ref_run[2], usb, sio}
  localparam int NV = 8;
  localparam logic [17:0] STIM [NV] = '{
    {1'b1,1'b1,1'b1,1'b0,6'h3F,3'b111,1'b1,2'b11,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,6'h3F,3'b111,1'b1,2'b11,1'b1,1'b1},
    {1'b1,1'b0,1'b0,1'b0,6'h3F,3'b111,1'b1,2'b11,1'b1,1'b1},
    {1'b0,1'b1,1'b0,1'b0,6'h3F,3'b111,1'b1,2'b11,1'b1,1'b1},
    {1'b1,1'b1,1'b0,1'b0,6'h2A,3'b010,1'b0,2'b01,1'b0,1'b1},
    {1'b1,1'b1,1'b0,1'b0,6'h15,3'b101,1'b1,2'b10,1'b1,1'b0},
    {1'b1,1'b1,1'b0,1'b1,6'h3F,3'b111,1'b1,2'b11,1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b0,6'h3F,3'b111,1'b1,2'b11,1'b1,1'b1}
  };
  // High-phase result: {cpu_t, cpu_cs, cpu_c_oe, clk_oe, ref0_oe, pci[6], sdram[13], ref[2], usb, sio}
  localparam logic [27:0] EXPV [NV] = '{
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'h3F,13'h1FFF,2'b10,1'b1,1'b1},
    {1'b0,1'b0,1'b0,1'b1,1'b0,6'h3F,13'h1FFF,2'b10,1'b1,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b1,6'h3F,13'h1FFF,2'b11,1'b1,1'b1},
    {1'b0,1'b0,1'b0,1'b1,1'b1,6'h00,13'h0000,2'b00,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b1,6'h2A,13'h00F0,2'b01,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b1,6'h15,13'h1F0F,2'b10,1'b1,1'b0},
    {1'b1,1'b1,1'b0,1'b0,1'b0,6'h3F,13'h1FFF,2'b11,1'b1,1'b1},
    {1'b0,1'b0,1'b0,1'b1,1'b0,6'h00,13'h0000,2'b00,1'b0,1'b0}
  };
  localparam string VTAG [NV] = '{"R3", "R2", "R5", "R1", "R4", "R4", "R6", "R1"};

  task automatic apply(input logic [17:0] s);
    {pwrdn_n, cpustop_n, mode_strap, test_hiz, pci_run, sdram_grp_run,
     sdram_tail_run, ref_run, usb_run, sio_run} = s;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [27:0] snap();
    return {cpu_t, cpu_cs, cpu_c_oe, clk_oe, ref0_oe, pci_out, sdram_out, ref_out, usb_out, sio_out};
  endfunction

  task automatic mid_high(); @(posedge clk); #2; endtask
  task automatic mid_low();  @(negedge clk); #2; endtask

  initial begin
    rst_n = 1'b0;
    apply(STIM[0]);
    repeat (3) @(posedge clk);
    #2;
    // R11: everything quiet in reset even with all run bits set
    check("R11", {4'd0, snap() & 28'hC7FFFFF}, 32'd0);
    mid_low();
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      mid_low();
      apply(STIM[i]);
      repeat (4) @(posedge clk);
      #2;
      check(VTAG[i], {4'd0, snap()}, {4'd0, EXPV[i]});
    end

    // All lanes running, stop pin not selected
    mid_low();
    apply({1'b1,1'b1,1'b0,1'b0,6'h3F,3'b111,1'b1,2'b11,1'b1,1'b1});
    repeat (4) @(posedge clk);
    mid_low();
    check("R7 complement in low phase", {31'd0, cpu_c}, 32'd1);
    // R8: no gated output is high while its clock is low
    check("R8", {4'd0, snap() & 28'hC7FFFFF}, 32'd0);
    mid_high();
    check("R7 complement in high phase", {31'd0, cpu_c}, 32'd0);

    // R9: run bit cleared in a low phase
    mid_low();
    pci_run[0] = 1'b0;
    mid_high();
    check("R9 next pulse kept", {31'd0, pci_out[0]}, 32'd1);
    mid_high();
    check("R9 following pulse gated", {31'd0, pci_out[0]}, 32'd0);
    mid_low();
    pci_run[0] = 1'b1;
    mid_high();
    check("R9 still off", {31'd0, pci_out[0]}, 32'd0);
    mid_high();
    check("R9 back on", {31'd0, pci_out[0]}, 32'd1);

    // R10: two-flop power-down latency
    mid_low();
    pwrdn_n = 1'b0;
    mid_high();
    check("R10 pd pulse 1", {31'd0, sio_out}, 32'd1);
    mid_high();
    check("R10 pd pulse 2", {31'd0, sio_out}, 32'd1);
    mid_high();
    check("R10 pd pulse 3", {31'd0, sio_out}, 32'd0);
    mid_low();
    pwrdn_n = 1'b1;
    mode_strap = 1'b1;
    repeat (4) @(posedge clk);

    // R10: same latency on the stop path (R2 lanes)
    mid_low();
    cpustop_n = 1'b0;
    mid_high();
    check("R10 stop pulse 1", {31'd0, cpu_t}, 32'd1);
    mid_high();
    check("R10 stop pulse 2", {31'd0, cpu_t}, 32'd1);
    mid_high();
    check("R10 stop pulse 3", {30'd0, cpu_t, usb_out}, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule